// File: doc/BRIEF.md
# Self-Clocked Serial Converter Result Receiver

This block sits on the host side of a link to a converter that supplies its own serial clock and runs one conversion after another. It watches two lines driven from outside, a serial clock and a serial data line. Both pass through synchronizers into the host clock domain. The block then follows the converter through its busy and output phases, takes one data bit on each rising edge of the serial clock, and delivers the captured result: a sign bit and a 16-bit magnitude.

While the converter is busy, both lines sit high. The converter reports that a result is ready by pulling both lines low. The frame then runs for exactly 19 rising clock edges, and the line carries these bits in this order:

1. a status bit that must be 0 for the frame to be accepted;
2. a reserved bit;
3. the sign;
4. sixteen data bits, most significant first.

After the last edge the data line rises again to mark the next conversion. If the frame is good, the block raises a one-cycle valid strobe and holds the result until the next good frame. If the frame breaks the protocol, the block raises a one-cycle error pulse instead and throws the frame away.

Top module: `adc_frame_rx`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `frame_valid`, `frame_err`, `frame_sign` and `frame_data` are all 0.
- R2: A frame starts only when both synchronized lines have first been seen high together and are then seen low together. Serial clock edges seen before that point cause neither `frame_valid` nor `frame_err`. This includes edges after reset that were never preceded by the idle-high state, and edges while the data line stays high.
- R3: Each synchronized rising serial clock edge captures one data-line bit, first-received bit in frame position 18. After 19 edges, position 16 appears on `frame_sign` and positions 15..0 appear on `frame_data[15:0]` (position 15 is the MSB).
- R4: `frame_valid` is high for exactly one host cycle per accepted frame. `frame_data` and `frame_sign` change only in that cycle and otherwise hold their value.
- R5: If the frame status bit (position 18) is 1, the frame raises `frame_err` for one cycle, raises no `frame_valid`, and leaves `frame_data` and `frame_sign` unchanged.
- R6: A frame is accepted only when the synchronized data line is high after the 19th edge. The frame is rejected with `frame_err` if, after the 19th edge, either of these happens:
  - the data line stays low for more than `stall_limit` host cycles;
  - the serial clock falls again before the data line rises.
- R7: If the synchronized serial clock stays high for more than `stall_limit` consecutive host cycles between the frame start and the 19th edge, the frame is rejected with `frame_err`. The receiver then accepts the next proper frame. A high time of at most `stall_limit` cycles does not cause an error.
- R8: The value of the reserved bit (position 17) has no effect on acceptance or on the outputs.
- R9: `frame_valid` and `frame_err` are never high together. Frames separated by short busy phases are each accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; must run at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial clock from the converter (asynchronous) |
| sdo_in | input | 1 | Serial data from the converter (asynchronous) |
| stall_limit | input | TMO_W | Limit, in host cycles, on the serial clock high time inside a frame and on the wait for the data line to rise after the frame |
| frame_valid | output | 1 | One-cycle strobe for an accepted frame |
| frame_err | output | 1 | One-cycle pulse for a discarded frame |
| frame_sign | output | 1 | Sign bit of the last accepted frame |
| frame_data | output | 16 | Magnitude of the last accepted frame |

## Verification
The bench goes after these corner cases:

- **Serial clock activity that is not a frame.** It toggles the serial clock after reset without the idle-high state, and again while the data line is held high. A receiver that starts on any falling edge would produce a stray strobe or error.
- **Status bit and tail failures.** It sends a frame with the status bit set and a frame whose data line never rises after the last edge. A design that skipped either check would overwrite the held result.
- **Serial clock high time inside a frame.** One frame stretches a high phase to just under the limit, which must still be accepted. Another holds the clock high well past the limit, which must be rejected, and the bench then confirms that the next frame is received. An off-by-one timeout or a receiver that stays stuck would show up here.
- **Reserved bit and bit order.** Set reserved bits and asymmetric data patterns catch a bit-order or field-position mistake.

// File: rtl/adcrx_pkg.sv
package adcrx_pkg;

    localparam int FRAME_BITS = 19;
    localparam int DATA_BITS  = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        RX_WAIT_IDLE,
        RX_CONV,
        RX_SHIFT,
        RX_TAIL
    } rx_state_e;

    typedef struct packed {
        logic                 status;
        logic                 rsvd;
        logic                 sign;
        logic [DATA_BITS-1:0] data;
    } frame_t;

    function automatic frame_t to_frame(input logic [FRAME_BITS-1:0] raw);
        return frame_t'(raw);
    endfunction

    function automatic logic frame_ok(input frame_t f);
        return !f.status;
    endfunction

endpackage

// File: rtl/adcrx_sync.sv
module adcrx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/adcrx_edge.sv
module adcrx_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;
    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end
    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/adcrx_shift.sv
module adcrx_shift
    import adcrx_pkg::*;
#(
    parameter int BITS  = FRAME_BITS,
    localparam int CW   = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            en,
    input  logic            din,
    output logic [BITS-1:0] word,
    output logic            done
);
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word  <= '0;
            count <= '0;
        end else if (en && (count < CW'(BITS))) begin
            word  <= {word[BITS-2:0], din};
            count <= count + 1'b1;
        end
    end

    assign done = (count == CW'(BITS));
endmodule

// File: rtl/adcrx_ctrl.sv
module adcrx_ctrl
    import adcrx_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_s,
    input  logic                 sdo_s,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic                 done,
    input  frame_t               word,
    input  logic [TMO_W-1:0]     stall_limit,
    output logic                 clr,
    output logic                 shift_en,
    output logic                 valid,
    output logic                 err,
    output logic                 sign,
    output logic [DATA_BITS-1:0] data
);
    rx_state_e        state;
    logic [TMO_W-1:0] tmr;

    assign clr      = (state == RX_CONV) && !sck_s && !sdo_s;
    assign shift_en = (state == RX_SHIFT) && sck_rise && !done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_WAIT_IDLE;
            tmr   <= '0;
            valid <= 1'b0;
            err   <= 1'b0;
            sign  <= 1'b0;
            data  <= '0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            unique case (state)
                RX_WAIT_IDLE: begin
                    tmr <= '0;
                    if (sck_s && sdo_s) state <= RX_CONV;
                end
                RX_CONV: begin
                    tmr <= '0;
                    if (!sck_s && !sdo_s) state <= RX_SHIFT;
                end
                RX_SHIFT: begin
                    if (done) begin
                        state <= RX_TAIL;
                        tmr   <= '0;
                    end else if (sck_s) begin
                        if (tmr >= stall_limit) begin
                            err   <= 1'b1;
                            state <= RX_WAIT_IDLE;
                            tmr   <= '0;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end else begin
                        tmr <= '0;
                    end
                end
                RX_TAIL: begin
                    if (sdo_s) begin
                        if (frame_ok(word)) begin
                            valid <= 1'b1;
                            data  <= word.data;
                            sign  <= word.sign;
                        end else begin
                            err <= 1'b1;
                        end
                        state <= RX_WAIT_IDLE;
                    end else if (sck_fall || (tmr >= stall_limit)) begin
                        err   <= 1'b1;
                        state <= RX_WAIT_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= RX_WAIT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
    import adcrx_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_in,
    input  logic                 sdo_in,
    input  logic [TMO_W-1:0]     stall_limit,
    output logic                 frame_valid,
    output logic                 frame_err,
    output logic                 frame_sign,
    output logic [DATA_BITS-1:0] frame_data
);
    logic [1:0]            sync_q;
    logic                  sck_sync;
    logic                  sdo_sync;
    logic                  sck_rise;
    logic                  sck_fall;
    logic                  clr;
    logic                  shift_en;
    logic                  done;
    logic [FRAME_BITS-1:0] raw_word;

    adcrx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck_in, sdo_in}),
        .q   (sync_q)
    );
    assign sck_sync = sync_q[1];
    assign sdo_sync = sync_q[0];

    adcrx_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (sck_sync),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    adcrx_shift #(.BITS(FRAME_BITS)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .en   (shift_en),
        .din  (sdo_sync),
        .word (raw_word),
        .done (done)
    );

    adcrx_ctrl #(.TMO_W(TMO_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sck_s       (sck_sync),
        .sdo_s       (sdo_sync),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .done        (done),
        .word        (to_frame(raw_word)),
        .stall_limit (stall_limit),
        .clr         (clr),
        .shift_en    (shift_en),
        .valid       (frame_valid),
        .err         (frame_err),
        .sign        (frame_sign),
        .data        (frame_data)
    );
endmodule

// File: rtl/adcrx_chk.sv
module adcrx_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_valid,
    input logic        frame_err,
    input logic        frame_sign,
    input logic [15:0] frame_data,
    input logic        sdo_s
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_q) begin
            reset_clear_chk: assert (!frame_valid && !frame_err && !frame_sign && frame_data == '0);
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |-> ($stable(frame_data) && $stable(frame_sign)));

    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    // R6
    valid_after_sdo_high_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> $past(sdo_s));

    // R9
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_valid && frame_err));
endmodule

bind adc_frame_rx adcrx_chk u_adcrx_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .frame_err   (frame_err),
    .frame_sign  (frame_sign),
    .frame_data  (frame_data),
    .sdo_s       (sdo_sync)
);

// File: tb/adc_frame_rx_bench.sv
module adc_frame_rx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        sdo = 1'b0;
    logic [15:0] limit = 16'd20;
    logic        frame_valid, frame_err, frame_sign;
    logic [15:0] frame_data;

    adc_frame_rx u_adc_frame_rx (
        .clk (clk), .rst (rst), .sck_in (sck), .sdo_in (sdo),
        .stall_limit (limit), .frame_valid (frame_valid),
        .frame_err (frame_err), .frame_sign (frame_sign),
        .frame_data (frame_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // observation, away from the active edge
    int          vcnt = 0, ecnt = 0, wide = 0, both = 0;
    logic        prev_v = 1'b0;
    logic [15:0] last_data = '0;
    logic        last_sign = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_valid) begin
                vcnt++;
                last_data = frame_data;
                last_sign = frame_sign;
            end
            if (frame_valid && prev_v) wide++;
            if (frame_err) ecnt++;
            if (frame_valid && frame_err) both++;
        end
        prev_v = frame_valid;
    end

    // {tail_ok, status, reserved, sign, data}
    localparam logic [19:0] VEC [6] = '{
        {1'b1, 1'b0, 1'b0, 1'b1, 16'hA5C3},
        {1'b1, 1'b0, 1'b1, 1'b0, 16'h0001},
        {1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF},
        {1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
        {1'b0, 1'b0, 1'b0, 1'b1, 16'h8000},
        {1'b1, 1'b0, 1'b1, 1'b1, 16'h7FFE}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_frame(input logic [18:0] bits, input bit tail_ok, input int hold9);
        sck = 1'b1; sdo = 1'b1; tick(10);
        sck = 1'b0; sdo = 1'b0; tick(2);
        sdo = bits[18];        tick(2);
        sck = 1'b1;            tick(4);
        for (int i = 17; i >= 0; i--) begin
            sck = 1'b0; sdo = bits[i]; tick(4);
            sck = 1'b1; tick(i == 9 ? hold9 : 4);
        end
        if (!tail_ok) tick(40);
        sdo = 1'b1; tick(12);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int v0, e0;
        logic [15:0] d0;
        logic        s0;
        tick(5);
        // R1: outputs clear while reset is held
        check(!frame_valid && !frame_err, "R1 strobes", {frame_valid, frame_err}, 0);
        check(frame_data == 0 && !frame_sign, "R1 result", {frame_sign, frame_data}, 0);
        rst = 1'b0;
        tick(1);
        check(!frame_valid && !frame_err && frame_data == 0, "R1 after release",
              {frame_valid, frame_err, frame_data}, 0);

        // R2: clock pulses with no idle-high state first, then with data high
        for (int i = 0; i < 19; i++) begin
            sck = 1'b1; tick(4); sck = 1'b0; tick(4);
        end
        sdo = 1'b1;
        for (int i = 0; i < 10; i++) begin
            sck = 1'b1; tick(4); sck = 1'b0; tick(4);
        end
        tick(20);
        check(vcnt == 0, "R2 no strobe", vcnt, 0);
        check(ecnt == 0, "R2 no error", ecnt, 0);

        // table walk: R3 R4 R5 R6 R8 R9
        foreach (VEC[k]) begin
            logic [18:0] bits;
            bit          tail_ok, exp_v;
            string       req;
            bits    = VEC[k][18:0];
            tail_ok = VEC[k][19];
            exp_v   = !bits[18] && tail_ok;
            req     = bits[18] ? "R5" : (!tail_ok ? "R6" : (bits[17] ? "R8" : "R3"));
            v0 = vcnt; e0 = ecnt; d0 = last_data; s0 = last_sign;
            send_frame(bits, tail_ok, 4);
            check(vcnt - v0 == int'(exp_v), {req, " strobe count"}, vcnt - v0, exp_v);
            check(ecnt - e0 == int'(!exp_v), {req, " error count"}, ecnt - e0, !exp_v);
            if (exp_v) begin
                check(last_data == bits[15:0], {req, " data"}, last_data, bits[15:0]);
                check(last_sign == bits[16], {req, " sign"}, last_sign, bits[16]);
                check(frame_data == bits[15:0], {req, " data held"}, frame_data, bits[15:0]);
            end else begin
                check(frame_data == d0 && frame_sign == s0, "R4 hold after reject",
                      {frame_sign, frame_data}, {s0, d0});
            end
        end

        // R7: high phase just under the limit is accepted
        v0 = vcnt; e0 = ecnt;
        send_frame({3'b001, 16'h3C5A}, 1'b1, 15);
        check(vcnt - v0 == 1 && ecnt == e0, "R7 long high accepted", vcnt - v0, 1);
        check(frame_data == 16'h3C5A, "R7 long high data", frame_data, 16'h3C5A);

        // R7: stall beyond the limit is rejected
        v0 = vcnt; e0 = ecnt; d0 = frame_data;
        sck = 1'b1; sdo = 1'b1; tick(10);
        sck = 1'b0; sdo = 1'b0; tick(4);
        sck = 1'b1; tick(4);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b0; sdo = i[0]; tick(4);
            sck = 1'b1; tick(4);
        end
        tick(60);
        sdo = 1'b1; tick(10);
        check(ecnt - e0 == 1, "R7 stall error", ecnt - e0, 1);
        check(vcnt == v0 && frame_data == d0, "R7 stall no strobe", vcnt - v0, 0);

        // R7: recovery on the next frame
        v0 = vcnt;
        send_frame({3'b000, 16'h1234}, 1'b1, 4);
        check(vcnt - v0 == 1 && frame_data == 16'h1234, "R7 recovery", frame_data, 16'h1234);

        // R4 / R9 global observations
        check(wide == 0, "R4 strobe width", wide, 0);
        check(both == 0, "R9 exclusive", both, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule